// File: doc/BRIEF.md
# Floating-Point Pipeline Reservation Scoreboard

This block guards the floating-point pipeline against structural hazards. It keeps a table of which pipeline resources are already claimed for each of the next DEPTH cycles. There are six resources: the entry stage (S0), the main middle stage (S1), the write-back stage (S2), the iterative divide/root stage (DV), and two integer-multiply sub-units (MA, MB) that sit beside S1.

Each instruction is offered in the first cycle after issue with a 3-bit class code. Every class has a fixed multi-cycle claim pattern. The pattern is compared against the table in the same cycle. If any resource would be claimed twice, or if a multiply sub-unit and S1 would be busy in the same cycle, `stall_o` rises combinationally and nothing is recorded. Otherwise the pattern is merged into the table.

The table moves one cycle closer to the present on every clock. Long divides can therefore overlap with short operations that follow them, as long as those operations avoid DV.

Top module: `fpu_rsv_scoreboard`

## Requirements
- R1: After reset is released, the table is empty. With `valid_i` low, `stall_o` and `accept_o` are 0, and any class offered as the first operation is accepted.
- R2: Class 0 (single-precision add/multiply/compare) claims S0+S1 in slot 0 and S2 in slot 1. Slot n is the nth cycle counted from the offer cycle, which is slot 0. Two such operations offered back to back are both accepted.
- R3: Class 1 (single-precision divide) claims DV in slots 0..9, S0+S1 in slot 0, S2 in slot 1, S1 in slot 9 and S2 in slot 10. A later class 1 offer stalls until the first one has left DV. A class 0 offer in slot 1 overlaps it without stalling.
- R4: Class 2 (square root) has the class 1 pattern shortened by one cycle: DV in slots 0..8, S0+S1 in slot 0, S2 in slot 1, S1 in slot 8 and S2 in slot 9.
- R5: Class 3 (double-precision add/subtract/multiply) claims S0+S1 in slot 0, S1+S2 in slots 1..5 and S2 in slot 6.
- R6: Class 4 (double-precision divide) claims DV in slots 0..21 and S0+S1 in slot 0. It claims S1+S2 in slots 1, 20 and 21, S2 in slot 2, S1 in slot 19 and S2 in slot 22.
- R7: Class 5 (precision conversion) claims S0+S1 in slot 0, S1+S2 in slot 1 and S2 in slot 2.
- R8: Class 6 (integer multiply) claims MA in slot 0 and one sub-unit in each of slots 1..3, then S2 in slot 4. For slots 1..3 it takes MB when MB is free in that slot, and MA otherwise. As a result, two multiplies offered in consecutive cycles are both accepted.
- R9: MA or MB is never reserved in the same slot as S1. Any offer that would create that overlap stalls.
- R10: Class 7 (status-register load) claims S1 in slots 1..3 and nothing in slot 0.
- R11: `stall_o` is 1 only while `valid_i` is 1 and some claim collides with the table. `accept_o` equals `valid_i` and not `stall_o` and not `flush_i`. A stalled or unoffered cycle adds no reservation.
- R12: `flush_i` empties the table at the next edge. An offer made in a flush cycle is not recorded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Clears all reservations; blocks commit this cycle |
| valid_i | input | 1 | An operation is offered this cycle |
| op_class_i | input | 3 | Class code of the offered operation (0..7, see R2..R10) |
| stall_o | output | 1 | Structural conflict for the offered operation |
| accept_o | output | 1 | Offered operation has been recorded |

## Verification
The bench builds the block with the default DEPTH of 24. This is one more slot than the longest pattern, the double-precision divide, which ends at slot 22. At this depth the full divide window and its tail fit in the table, so the bench can count every stalled cycle until a second divide gets through. Vectors with repeat counts show the exact cycle at which each class stops blocking a follower. They also show both sub-unit choices of the multiply, and how flush and reset interact with a divide that is still in flight.

// File: rtl/fpu_rsv_pkg.sv
package fpu_rsv_pkg;
  localparam int NUM_RES = 6;
  localparam int PAT_W   = NUM_RES + 1;
  localparam int OP_W    = 3;

  localparam int RB_S0 = 0;
  localparam int RB_S1 = 1;
  localparam int RB_S2 = 2;
  localparam int RB_DV = 3;
  localparam int RB_MA = 4;
  localparam int RB_MB = 5;
  localparam int RB_MX = 6;  // "either multiply sub-unit", resolved per slot

  typedef enum logic [OP_W-1:0] {
    OP_SP_ARITH = 3'd0,
    OP_SP_DIV   = 3'd1,
    OP_SP_SQRT  = 3'd2,
    OP_DP_ARITH = 3'd3,
    OP_DP_DIV   = 3'd4,
    OP_CONV     = 3'd5,
    OP_INT_MUL  = 3'd6,
    OP_FPSCR_LD = 3'd7
  } op_cls_e;

  function automatic logic [PAT_W-1:0] slot_claim(op_cls_e c, int s);
    logic [PAT_W-1:0] p;
    p = '0;
    case (c)
      OP_SP_ARITH: begin
        if (s == 0) begin p[RB_S0] = 1'b1; p[RB_S1] = 1'b1; end
        if (s == 1) p[RB_S2] = 1'b1;
      end
      OP_SP_DIV: begin
        if (s <= 9) p[RB_DV] = 1'b1;
        if (s == 0) begin p[RB_S0] = 1'b1; p[RB_S1] = 1'b1; end
        if (s == 1 || s == 10) p[RB_S2] = 1'b1;
        if (s == 9) p[RB_S1] = 1'b1;
      end
      OP_SP_SQRT: begin
        if (s <= 8) p[RB_DV] = 1'b1;
        if (s == 0) begin p[RB_S0] = 1'b1; p[RB_S1] = 1'b1; end
        if (s == 1 || s == 9) p[RB_S2] = 1'b1;
        if (s == 8) p[RB_S1] = 1'b1;
      end
      OP_DP_ARITH: begin
        if (s == 0) begin p[RB_S0] = 1'b1; p[RB_S1] = 1'b1; end
        if (s >= 1 && s <= 5) begin p[RB_S1] = 1'b1; p[RB_S2] = 1'b1; end
        if (s == 6) p[RB_S2] = 1'b1;
      end
      OP_DP_DIV: begin
        if (s <= 21) p[RB_DV] = 1'b1;
        if (s == 0) begin p[RB_S0] = 1'b1; p[RB_S1] = 1'b1; end
        if (s == 1 || s == 20 || s == 21) begin p[RB_S1] = 1'b1; p[RB_S2] = 1'b1; end
        if (s == 2 || s == 22) p[RB_S2] = 1'b1;
        if (s == 19) p[RB_S1] = 1'b1;
      end
      OP_CONV: begin
        if (s == 0) begin p[RB_S0] = 1'b1; p[RB_S1] = 1'b1; end
        if (s == 1) begin p[RB_S1] = 1'b1; p[RB_S2] = 1'b1; end
        if (s == 2) p[RB_S2] = 1'b1;
      end
      OP_INT_MUL: begin
        if (s == 0) p[RB_MA] = 1'b1;
        if (s >= 1 && s <= 3) p[RB_MX] = 1'b1;
        if (s == 4) p[RB_S2] = 1'b1;
      end
      OP_FPSCR_LD: begin
        if (s >= 1 && s <= 3) p[RB_S1] = 1'b1;
      end
      default: p = '0;
    endcase
    return p;
  endfunction
endpackage

// File: rtl/fpu_rsv_pattern.sv
module fpu_rsv_pattern
  import fpu_rsv_pkg::*;
#(
  parameter int DEPTH = 24
) (
  input  logic [OP_W-1:0]             cls_i,
  output logic [DEPTH-1:0][PAT_W-1:0] pat_o
);
  for (genvar k = 0; k < DEPTH; k++) begin : g_slot
    assign pat_o[k] = slot_claim(op_cls_e'(cls_i), k);
  end
endmodule

// File: rtl/fpu_rsv_slot_res.sv
module fpu_rsv_slot_res
  import fpu_rsv_pkg::*;
(
  input  logic [PAT_W-1:0]   claim_i,
  input  logic               mb_busy_i,
  output logic [NUM_RES-1:0] take_o
);
  // "either" claim prefers MB so a following multiply can start on MA
  always_comb begin
    take_o = claim_i[NUM_RES-1:0];
    if (claim_i[RB_MX]) begin
      if (!mb_busy_i) take_o[RB_MB] = 1'b1;
      else            take_o[RB_MA] = 1'b1;
    end
  end
endmodule

// File: rtl/fpu_rsv_table.sv
module fpu_rsv_table
  import fpu_rsv_pkg::*;
#(
  parameter int DEPTH = 24
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          flush_i,
  input  logic                          commit_i,
  input  logic [DEPTH-1:0][NUM_RES-1:0] take_i,
  output logic                          conflict_o,
  output logic [DEPTH-1:0]              mb_busy_o
);
  logic [DEPTH-1:0][NUM_RES-1:0] slot_q, slot_d;
  logic [DEPTH-1:0]              hit;

  for (genvar k = 0; k < DEPTH; k++) begin : g_cmp
    logic mul_new, mul_old;
    assign mul_new  = take_i[k][RB_MA] | take_i[k][RB_MB];
    assign mul_old  = slot_q[k][RB_MA] | slot_q[k][RB_MB];
    assign hit[k]   = (|(take_i[k] & slot_q[k]))
                    | (take_i[k][RB_S1] & mul_old)
                    | (mul_new & slot_q[k][RB_S1]);
    assign mb_busy_o[k] = slot_q[k][RB_MB];

    a_r9_no_s1_mul_overlap: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(slot_q[k][RB_S1] && (slot_q[k][RB_MA] || slot_q[k][RB_MB])));
  end

  assign conflict_o = |hit;

  for (genvar k = 0; k < DEPTH - 1; k++) begin : g_shift
    assign slot_d[k] = slot_q[k+1] | (commit_i ? take_i[k+1] : '0);

    a_r11_nothing_new_without_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !commit_i |=> ((slot_q[k] & ~$past(slot_q[k+1])) == '0));
  end
  assign slot_d[DEPTH-1] = '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      slot_q <= '0;
    else if (flush_i) slot_q <= '0;
    else              slot_q <= slot_d;
  end

  a_r12_flush_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (slot_q == '0));
endmodule

// File: rtl/fpu_rsv_scoreboard.sv
module fpu_rsv_scoreboard
  import fpu_rsv_pkg::*;
#(
  parameter int DEPTH = 24  // must cover the longest pattern (23 slots)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            flush_i,
  input  logic            valid_i,
  input  logic [OP_W-1:0] op_class_i,
  output logic            stall_o,
  output logic            accept_o
);
  logic [DEPTH-1:0][PAT_W-1:0]   pat;
  logic [DEPTH-1:0][NUM_RES-1:0] take;
  logic [DEPTH-1:0]              mb_busy;
  logic                          conflict;

  fpu_rsv_pattern #(.DEPTH(DEPTH)) u_pat (
    .cls_i (op_class_i),
    .pat_o (pat)
  );

  for (genvar k = 0; k < DEPTH; k++) begin : g_res
    fpu_rsv_slot_res u_res (
      .claim_i   (pat[k]),
      .mb_busy_i (mb_busy[k]),
      .take_o    (take[k])
    );
  end

  fpu_rsv_table #(.DEPTH(DEPTH)) u_tab (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .flush_i    (flush_i),
    .commit_i   (accept_o),
    .take_i     (take),
    .conflict_o (conflict),
    .mb_busy_o  (mb_busy)
  );

  assign stall_o  = valid_i & conflict;
  assign accept_o = valid_i & ~stall_o & ~flush_i;

  a_r11_stall_needs_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> valid_i);
  a_r12_no_commit_on_flush: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |-> !accept_o);
endmodule

// File: tb/fpu_rsv_scoreboard_tb.sv
`timescale 1ns/1ps
module fpu_rsv_scoreboard_tb;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       flush_i = 1'b0;
  logic       valid_i = 1'b0;
  logic [2:0] op_class_i = 3'd0;
  logic       stall_o, accept_o;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  fpu_rsv_scoreboard u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .flush_i(flush_i), .valid_i(valid_i),
    .op_class_i(op_class_i), .stall_o(stall_o), .accept_o(accept_o)
  );

  typedef struct packed {
    logic       fl;
    logic       vl;
    logic [2:0] cl;
    logic       ex;   // expected stall
    logic [4:0] rp;   // repeat count
    logic [3:0] rq;   // requirement number
  } vec_t;

  localparam int NV = 48;
  localparam vec_t VEC [NV] = '{
    // R2: SP arith back to back
    '{1'b1,1'b0,3'd0,1'b0,5'd1,4'd2}, '{1'b0,1'b1,3'd0,1'b0,5'd2,4'd2},
    // R5 / R11: DP arith, idle cycle, then SP arith blocked on S1 four cycles
    '{1'b1,1'b0,3'd0,1'b0,5'd1,4'd5}, '{1'b0,1'b1,3'd3,1'b0,5'd1,4'd5},
    '{1'b0,1'b0,3'd0,1'b0,5'd1,4'd11}, '{1'b0,1'b1,3'd0,1'b1,5'd4,4'd5},
    '{1'b0,1'b1,3'd0,1'b0,5'd1,4'd5},
    // R3: SP divide, overlapping arith, second divide waits
    '{1'b1,1'b0,3'd0,1'b0,5'd1,4'd3}, '{1'b0,1'b1,3'd1,1'b0,5'd1,4'd3},
    '{1'b0,1'b1,3'd0,1'b0,5'd1,4'd3}, '{1'b0,1'b1,3'd1,1'b1,5'd8,4'd3},
    '{1'b0,1'b1,3'd1,1'b0,5'd1,4'd3},
    // R4: root frees DV one cycle sooner
    '{1'b1,1'b0,3'd0,1'b0,5'd1,4'd4}, '{1'b0,1'b1,3'd2,1'b0,5'd1,4'd4},
    '{1'b0,1'b1,3'd1,1'b1,5'd8,4'd4}, '{1'b0,1'b1,3'd1,1'b0,5'd1,4'd4},
    // R6: DP divide
    '{1'b1,1'b0,3'd0,1'b0,5'd1,4'd6}, '{1'b0,1'b1,3'd4,1'b0,5'd1,4'd6},
    '{1'b0,1'b1,3'd0,1'b1,5'd1,4'd6}, '{1'b0,1'b1,3'd0,1'b0,5'd1,4'd6},
    '{1'b0,1'b1,3'd1,1'b1,5'd19,4'd6}, '{1'b0,1'b1,3'd1,1'b0,5'd1,4'd6},
    // R9: multiply holds sub-units, S1 user waits
    '{1'b1,1'b0,3'd0,1'b0,5'd1,4'd9}, '{1'b0,1'b1,3'd6,1'b0,5'd1,4'd9},
    '{1'b0,1'b1,3'd0,1'b1,5'd3,4'd9}, '{1'b0,1'b1,3'd0,1'b0,5'd1,4'd9},
    // R8: two multiplies overlap, third collides on MA
    '{1'b1,1'b0,3'd0,1'b0,5'd1,4'd8}, '{1'b0,1'b1,3'd6,1'b0,5'd1,4'd8},
    '{1'b0,1'b1,3'd6,1'b0,5'd1,4'd8}, '{1'b0,1'b1,3'd6,1'b1,5'd1,4'd8},
    // R10: status load holds S1 in slots 1..3
    '{1'b1,1'b0,3'd0,1'b0,5'd1,4'd10}, '{1'b0,1'b1,3'd7,1'b0,5'd1,4'd10},
    '{1'b0,1'b1,3'd0,1'b1,5'd3,4'd10}, '{1'b0,1'b1,3'd0,1'b0,5'd1,4'd10},
    // R9: status load blocks multiply via S1
    '{1'b1,1'b0,3'd0,1'b0,5'd1,4'd9}, '{1'b0,1'b1,3'd7,1'b0,5'd1,4'd9},
    '{1'b0,1'b1,3'd6,1'b1,5'd3,4'd9}, '{1'b0,1'b1,3'd6,1'b0,5'd1,4'd9},
    // R7: conversion
    '{1'b1,1'b0,3'd0,1'b0,5'd1,4'd7}, '{1'b0,1'b1,3'd5,1'b0,5'd1,4'd7},
    '{1'b0,1'b1,3'd0,1'b1,5'd1,4'd7}, '{1'b0,1'b1,3'd0,1'b0,5'd1,4'd7},
    // R12: flush drops in-flight divide; offer in flush cycle not recorded
    '{1'b1,1'b0,3'd0,1'b0,5'd1,4'd12}, '{1'b0,1'b1,3'd4,1'b0,5'd1,4'd12},
    '{1'b1,1'b0,3'd0,1'b0,5'd1,4'd12}, '{1'b0,1'b1,3'd1,1'b0,5'd1,4'd12},
    '{1'b1,1'b1,3'd4,1'b1,5'd1,4'd12}, '{1'b0,1'b1,3'd1,1'b0,5'd1,4'd12}
  };

  task automatic check(input string req, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic drive(input logic fl, input logic vl, input logic [2:0] cl);
    @(negedge clk);
    flush_i = fl; valid_i = vl; op_class_i = cl;
    #1;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    #1;
    check("R1", "stall_o idle", stall_o, 1'b0);
    check("R1", "accept_o idle", accept_o, 1'b0);

    for (int i = 0; i < NV; i++) begin
      for (int r = 0; r < int'(VEC[i].rp); r++) begin
        drive(VEC[i].fl, VEC[i].vl, VEC[i].cl);
        check($sformatf("R%0d", VEC[i].rq), $sformatf("stall_o v%0d", i), stall_o, VEC[i].ex);
        check("R11", $sformatf("accept_o v%0d", i), accept_o,
              VEC[i].vl & ~VEC[i].ex & ~VEC[i].fl);
      end
    end

    // R1: reset in the middle of a DP divide empties the table
    drive(1'b1, 1'b0, 3'd0);
    drive(1'b0, 1'b1, 3'd4);
    check("R1", "dp div accepted", accept_o, 1'b1);
    drive(1'b0, 1'b1, 3'd1);
    check("R1", "divide blocked before reset", stall_o, 1'b1);
    @(negedge clk);
    valid_i = 1'b0;
    rst_ni = 1'b0;
    @(negedge clk);
    rst_ni = 1'b1;
    drive(1'b0, 1'b1, 3'd1);
    check("R1", "divide after reset stall", stall_o, 1'b0);
    check("R1", "divide after reset accept", accept_o, 1'b1);

    // R11: busy table, valid low -> no stall
    drive(1'b0, 1'b0, 3'd1);
    check("R11", "no offer no stall", stall_o, 1'b0);
    drive(1'b0, 1'b1, 3'd1);
    check("R11", "table still holds divide", stall_o, 1'b1);

    drive(1'b0, 1'b0, 3'd0);
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule